// File: doc/BRIEF.md
# MII Management Bit-Bang Responder

This block plays the part of a single PHY on a serial management bus whose clock is not a real pin. Host software toggles a clock bit, a data-out bit and a direction bit in a control register. Every register write arrives here as a strobe, together with the new values of those three bits. The responder detects low-to-high steps of the clock bit and shifts the data-out bit into a 32-bit frame word. It decodes read and write frames and returns read data on a data-in bit. Host software reads that bit back through the same control register.

The PHY holds up to 32 registers of 16 bits. Each register has a reset value and a writable-bit mask, both computed at elaboration from a package function. A run of 32 ones on the data line resynchronises the frame counter. Management frames use a start-plus-opcode nibble of 6 for a read and 5 for a write. The PHY address field is 5 bits wide, and so is the register field.

Top module: `mdio_bitbang_phy`

## Requirements
- R1: Only a strobe whose clock bit is 1 while the clock bit of the previous strobe was 0 counts as an edge. Such an edge advances the bit counter and shifts the frame word. Any other strobe, and any cycle without a strobe, leaves the counter, the frame word and the data-in bit unchanged.
- R2: On each edge the frame word shifts left by one, and the data-out bit enters bit 0. When the direction bit is 1 (PHY drives) and the new count is 16 or more, a 0 enters bit 0 instead.
- R3: When the shifted frame word is all ones, the bit counter returns to 0, so 32 consecutive one bits always resynchronise the frame.
- R4: At the edge that brings the count to 16, bits 15:12 of the word hold the start-plus-opcode code, bits 11:7 the PHY address and bits 6:2 the register index. Code 6 loads the word with the addressed register, zero-extended. On that edge and on every later edge with the direction bit at 1, data-in takes bit 15 of the shifted word. Host software therefore reads register bits 14 down to 0 after edges 17 to 31.
- R5: At the edge that brings the count to 32, code 5 in bits 31:28 writes the data in bits 15:0. The write goes to the register indexed by bits 22:18, for the PHY address held in bits 27:23.
- R6: Only PHY address 1 responds. A read of any other address returns zero, and a write to any other address changes nothing.
- R7: A write changes only the bits set in the register's mask. The masks are 0xC01F for register 4 and 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25. Register 16 takes 0x0FFF, and every other register is read-only.
- R8: After reset, registers 0 to 5 hold 0x3100, 0xF02C, 0x7810, 0x0000, 0x0501 and 0x4181. Register 16 holds 0x0003, register 18 holds 0x0001, and all others hold zero. Data-in resets to 0.
- R9: Data-in keeps its value across strobes that do not update it, including edges with the direction bit at 0.
- R10: The bit counter saturates at its maximum and does not wrap. Edges past 32 that arrive without a preamble therefore never reach another decode point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe, one cycle |
| ctl_mdc | input | 1 | Management clock bit of the written value |
| ctl_mdo | input | 1 | Data-out bit of the written value |
| ctl_rd_dir | input | 1 | Direction bit, 1 = PHY drives data-in |
| mdi | output | 1 | Data-in bit returned to the host |

## Verification
A table of write-then-readback frames is applied. It covers the read-only, partly masked, fully writable and wrong-address cases, so a mask or address fault shows up as a wrong readback. Reset values are read directly. A read is run with the data-out bit held high during the PHY-driven phase, which separates a correct direction gate from one that lets host data leak into the word. Each frame bit is also sent with extra non-rising strobes that carry inverted data, which checks that only true edges count. A deliberately broken frame followed by a preamble tests resynchronisation. A frame sent after 32 idle edges, with no preamble, tells a saturating counter from a wrapping one.

// File: rtl/mdio_bb_pkg.sv
package mdio_bb_pkg;

   localparam int FRAME_BITS = 32;
   localparam int HALF_BITS  = 16;
   localparam int FIELD_W    = 5;
   localparam logic [3:0] CODE_RD = 4'h6;
   localparam logic [3:0] CODE_WR = 4'h5;

   // Power-on content of each PHY register
   function automatic logic [15:0] reg_reset(input int idx);
      case (idx)
         0:       return 16'h3100;
         1:       return 16'hF02C;
         2:       return 16'h7810;
         4:       return 16'h0501;
         5:       return 16'h4181;
         16:      return 16'h0003;
         18:      return 16'h0001;
         default: return 16'h0000;
      endcase
   endfunction

   // Bits a management write may change
   function automatic logic [15:0] reg_wmask(input int idx);
      if (idx == 4)                 return 16'hC01F;
      if (idx == 16)                return 16'h0FFF;
      if (idx >= 1 && idx <= 6)     return 16'hFFFF;
      if (idx >= 18 && idx <= 25)   return 16'hFFFF;
      return 16'h0000;
   endfunction

endpackage

// File: rtl/mdio_bb_regfile.sv
module mdio_bb_regfile
   import mdio_bb_pkg::*;
#(
   parameter int REG_CNT = 32,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [FIELD_W-1:0] rd_idx,
   output logic [DATA_W-1:0]  rd_data
);

   logic [DATA_W-1:0] regs [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reg_reset(i));
      localparam logic [DATA_W-1:0] WMASK   = DATA_W'(reg_wmask(i));
      if (WMASK == '0) begin : g_ro
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs[i] <= RST_VAL;
            else        regs[i] <= regs[i];
         end
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[i] <= RST_VAL;
            end else if (wr_en && wr_idx == FIELD_W'(i)) begin
               regs[i] <= (regs[i] & ~WMASK) | (wr_data & WMASK);
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_CNT; i++) begin
         if (rd_idx == FIELD_W'(i)) rd_data = regs[i];
      end
   end

endmodule

// File: rtl/mdio_bb_shifter.sv
module mdio_bb_shifter
   import mdio_bb_pkg::*;
#(
   parameter int CNT_W    = 6,
   parameter int PHY_ADDR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic               mdc,
   input  logic               mdo,
   input  logic               dir_rd,
   output logic               mdi,
   output logic [FIELD_W-1:0] rd_idx,
   input  logic [15:0]        rd_data,
   output logic               wr_en,
   output logic [FIELD_W-1:0] wr_idx,
   output logic [15:0]        wr_data,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               mdc_q
);

   localparam logic [CNT_W-1:0]   CNT_MAX  = '1;
   localparam logic [CNT_W-1:0]   CNT_HALF = CNT_W'(HALF_BITS);
   localparam logic [CNT_W-1:0]   CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [FIELD_W-1:0] MY_ADDR  = FIELD_W'(PHY_ADDR);

   logic [FRAME_BITS-1:0] word_q, word_sh, word_d;
   logic [CNT_W-1:0]      cnt_inc;
   logic                  rise, take_mdo, all_ones, rd_hit, phy_drive;
   logic [15:0]           rd_val;

   assign rise      = wr_stb & mdc & ~mdc_q;
   assign cnt_inc   = (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + 1'b1;
   assign phy_drive = dir_rd && (cnt_inc >= CNT_HALF);
   assign take_mdo  = mdo & ~phy_drive;
   assign word_sh   = {word_q[FRAME_BITS-2:0], take_mdo};
   assign all_ones  = (word_sh == '1);

   // header decode at the half-frame point
   assign rd_idx = word_sh[6:2];
   assign rd_val = (word_sh[11:7] == MY_ADDR) ? rd_data : 16'h0000;
   assign rd_hit = !all_ones && cnt_inc == CNT_HALF && word_sh[15:12] == CODE_RD;

   // write decode at the full-frame point
   assign wr_en   = rise && !all_ones && cnt_inc == CNT_FULL &&
                    word_sh[31:28] == CODE_WR && word_sh[27:23] == MY_ADDR;
   assign wr_idx  = word_sh[22:18];
   assign wr_data = word_sh[15:0];

   assign word_d = rd_hit ? {16'h0000, rd_val} : word_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q   <= 1'b0;
         bit_cnt <= '0;
         word_q  <= '0;
         mdi     <= 1'b0;
      end else if (wr_stb) begin
         mdc_q <= mdc;
         if (rise) begin
            word_q  <= word_d;
            bit_cnt <= all_ones ? '0 : cnt_inc;
            if (phy_drive) mdi <= word_sh[15];
         end
      end
   end

endmodule

// File: rtl/mdio_bitbang_phy.sv
module mdio_bitbang_phy
   import mdio_bb_pkg::*;
#(
   parameter int REG_CNT  = 32,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 6,
   parameter int PHY_ADDR = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_mdc,
   input  logic ctl_mdo,
   input  logic ctl_rd_dir,
   output logic mdi
);

   if (DATA_W != 16) begin : g_bad_data_w
      $error("DATA_W must be 16: register data field is fixed by the frame");
   end
   if (CNT_W < 6) begin : g_bad_cnt_w
      $error("CNT_W must hold a count of at least 32 without wrapping");
   end
   if (REG_CNT < 1 || REG_CNT > 32) begin : g_bad_reg_cnt
      $error("REG_CNT must be 1 to 32 for a 5-bit register field");
   end
   if (PHY_ADDR < 0 || PHY_ADDR > 31) begin : g_bad_addr
      $error("PHY_ADDR must fit the 5-bit address field");
   end

   logic [FIELD_W-1:0] rd_idx, wr_idx;
   logic [15:0]        rd_data, wr_data;
   logic               wr_en, mdc_q;
   logic [CNT_W-1:0]   bit_cnt;

   mdio_bb_shifter #(.CNT_W(CNT_W), .PHY_ADDR(PHY_ADDR)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ctl_wr),
      .mdc     (ctl_mdc),
      .mdo     (ctl_mdo),
      .dir_rd  (ctl_rd_dir),
      .mdi     (mdi),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .bit_cnt (bit_cnt),
      .mdc_q   (mdc_q)
   );

   mdio_bb_regfile #(.REG_CNT(REG_CNT), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/mdio_bitbang_phy_chk.sv
module mdio_bitbang_phy_chk #(
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_stb,
   input logic             mdc,
   input logic             mdc_q,
   input logic             dir_rd,
   input logic             mdi,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             wr_en
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(32);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(mdi) && $stable(bit_cnt)));                       // R1

   AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !(mdc && !mdc_q)) |=> $stable(bit_cnt));                    // R1

   AST_HOST_DIR_MDI: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_rd |=> $stable(mdi));                                             // R9

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mdc && !mdc_q) |=>
         (bit_cnt == '0 ||
          ($past(bit_cnt) != CNT_MAX && bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)) ||
          ($past(bit_cnt) == CNT_MAX && bit_cnt == CNT_MAX)));               // R10

   AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bit_cnt == CNT_FULL);                                        // R5

endmodule

bind mdio_bitbang_phy mdio_bitbang_phy_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (ctl_wr),
   .mdc     (ctl_mdc),
   .mdc_q   (mdc_q),
   .dir_rd  (ctl_rd_dir),
   .mdi     (mdi),
   .bit_cnt (bit_cnt),
   .wr_en   (wr_en)
);

// File: tb/mdio_bitbang_phy_bench.sv
module mdio_bitbang_phy_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;
   // {phy[4:0], reg[4:0], write data[15:0], expected readback[15:0]}
   localparam logic [41:0] VEC [NVEC] = '{
      {5'd1, 5'd0,  16'hFFFF, 16'h3100},   // read-only register  (R7)
      {5'd1, 5'd4,  16'h0000, 16'h0500},   // masked clear        (R7)
      {5'd1, 5'd4,  16'hFFFF, 16'hC51F},   // masked set          (R7)
      {5'd1, 5'd2,  16'h2A5A, 16'h2A5A},   // full write          (R5)
      {5'd1, 5'd16, 16'hFFFF, 16'h0FFF},   // 12-bit mask         (R7)
      {5'd2, 5'd2,  16'h1234, 16'h2A5A},   // foreign address     (R6)
      {5'd1, 5'd18, 16'h7ABC, 16'h7ABC},   // upper writable      (R7)
      {5'd1, 5'd31, 16'h1111, 16'h0000},   // read-only tail      (R7)
      {5'd1, 5'd6,  16'h0F0F, 16'h0F0F}    // full write          (R5)
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, ctl_mdc = 1'b0, ctl_mdo = 1'b0, ctl_rd_dir = 1'b0;
   logic mdi;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_bitbang_phy u_mdio_bitbang_phy (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mdc(ctl_mdc),
      .ctl_mdo(ctl_mdo), .ctl_rd_dir(ctl_rd_dir), .mdi(mdi)
   );

   task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic c, input logic d, input logic r);
      @(negedge clk);
      ctl_mdc = c; ctl_mdo = d; ctl_rd_dir = r; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic edge_bit(input logic d, input logic r);
      wr(1'b0, d, r);
      wr(1'b1, d, r);
   endtask

   task automatic preamble();
      repeat (32) edge_bit(1'b1, 1'b0);
   endtask

   task automatic write_frame(input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] data);
      logic [31:0] f;
      f = {4'b0101, phy, rg, 2'b10, data};
      preamble();
      for (int i = 31; i >= 0; i--) edge_bit(f[i], 1'b0);
   endtask

   task automatic read_frame(input logic [4:0] phy, input logic [4:0] rg,
                             input logic junk, output logic [15:0] got,
                             output logic last);
      logic [13:0] h;
      h = {4'b0110, phy, rg};
      preamble();
      for (int i = 13; i >= 0; i--) edge_bit(h[i], 1'b0);
      edge_bit(junk, 1'b0);            // bit 15
      edge_bit(junk, 1'b1);            // bit 16, PHY takes over
      got = 16'h0000;
      for (int k = 14; k >= 0; k--) begin
         edge_bit(junk, 1'b1);         // bits 17..31
         got[k] = mdi;
      end
      edge_bit(junk, 1'b1);            // bit 32
      last = mdi;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] got;
      logic        last;
      logic [15:0] rst_exp [8];
      logic [4:0]  rst_idx [8];
      rst_idx = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd16, 5'd18};
      rst_exp = '{16'h3100, 16'hF02C, 16'h7810, 16'h0000,
                  16'h0501, 16'h4181, 16'h0003, 16'h0001};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({15'd0, mdi}, 16'h0000, "R8 data-in after reset");

      // reset contents, bits 14:0 visible through a read (R8, R4)
      for (int i = 0; i < 8; i++) begin
         read_frame(1, rst_idx[i], 1'b0, got, last);
         chk(got, {1'b0, rst_exp[i][14:0]}, "R8 R4 reset readback");
      end
      read_frame(1, 5'd7, 1'b0, got, last);
      chk(got, 16'h0000, "R8 unlisted register zero");

      // foreign address reads zero (R6)
      read_frame(5'd3, 5'd0, 1'b0, got, last);
      chk(got, 16'h0000, "R6 read of foreign PHY");

      // host data held high in PHY-driven phase must not enter the word (R2)
      read_frame(1, 5'd1, 1'b1, got, last);
      chk(got, 16'h702C, "R2 R4 read with data-out high");
      chk({15'd0, last}, 16'h0000, "R2 data-out gated after bit 16");

      // table walk: write then read back (R4 R5 R6 R7)
      for (int v = 0; v < NVEC; v++) begin
         write_frame(VEC[v][41:37], VEC[v][36:32], VEC[v][31:16]);
         read_frame(1, VEC[v][36:32], 1'b0, got, last);
         chk(got, {1'b0, VEC[v][14:0]}, "R4 R5 R6 R7 table vector");
      end

      // only true rising edges count: extra strobes with inverted data (R1)
      begin
         logic [31:0] f;
         f = {4'b0101, 5'd1, 5'd5, 2'b10, 16'h0AAA};
         preamble();
         for (int i = 31; i >= 0; i--) begin
            wr(1'b0, ~f[i], 1'b0);
            wr(1'b0, ~f[i], 1'b0);
            wr(1'b1,  f[i], 1'b0);
            wr(1'b1, ~f[i], 1'b0);
         end
         read_frame(1, 5'd5, 1'b0, got, last);
         chk(got, 16'h0AAA, "R1 non-rising strobes ignored");
      end

      // broken frame then preamble resynchronises (R3)
      preamble();
      edge_bit(1'b0, 1'b0); edge_bit(1'b1, 1'b0); edge_bit(1'b0, 1'b0);
      write_frame(1, 5'd3, 16'h1357);
      read_frame(1, 5'd3, 1'b0, got, last);
      chk(got, 16'h1357, "R3 resync after aborted frame");

      // data-in holds across non-updating strobes (R9); reg0 = 0x3100
      preamble();
      begin
         logic [13:0] h;
         h = {4'b0110, 5'd1, 5'd0};
         for (int i = 13; i >= 0; i--) edge_bit(h[i], 1'b0);
      end
      edge_bit(1'b0, 1'b0);
      edge_bit(1'b0, 1'b1);            // bit 16
      edge_bit(1'b0, 1'b1);            // bit 17 -> bit 14 = 0
      edge_bit(1'b0, 1'b1);            // bit 18 -> bit 13 = 1
      edge_bit(1'b0, 1'b1);            // bit 19 -> bit 12 = 1
      chk({15'd0, mdi}, 16'h0001, "R4 data-in shows register bit");
      wr(1'b0, 1'b0, 1'b0);
      chk({15'd0, mdi}, 16'h0001, "R9 hold on non-edge strobe");
      edge_bit(1'b0, 1'b0);            // bit 20 in host direction
      chk({15'd0, mdi}, 16'h0001, "R9 hold on host-direction edge");
      repeat (12) edge_bit(1'b0, 1'b0);

      // saturation: 32 idle edges then a frame without preamble (R10)
      write_frame(1, 5'd6, 16'h0101);
      repeat (32) edge_bit(1'b0, 1'b0);
      begin
         logic [31:0] f;
         f = {4'b0101, 5'd1, 5'd6, 2'b10, 16'h7E7E};
         for (int i = 31; i >= 0; i--) edge_bit(f[i], 1'b0);
      end
      read_frame(1, 5'd6, 1'b0, got, last);
      chk(got, 16'h0101, "R10 no decode after saturation");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule